// File: doc/BRIEF.md
# Free-Running Timebase with Sticky Overflow Flag

This block is a periodic timebase for a small microcontroller. A 13-bit up-counter runs on the oscillator clock and has no read or write path. It starts at zero when reset is released. When the counter reaches the terminal value 0x1F39 it returns to zero, and that wrap is the overflow event. The full period is therefore 7994 advances, which is about 1 ms with an 8 MHz oscillator.

A period-select input doubles the period to about 2 ms. In that mode a clock enable lets the counter advance only on every second cycle, so the whole block stays in one clock domain.

Each overflow does three things:
- It raises a sticky overflow flag.
- It raises an interrupt request when interrupts are enabled.
- It emits a one-cycle tick pulse, which a companion watchdog or another timer can use.

Software clears the flag by reading the control/status register, which appears here as a one-cycle read strobe. If an overflow lands in the same cycle as that read, the overflow wins and the event is kept.

Top module: `ovf_timebase`

## Requirements
- R1: While reset is asserted and right after it is released, ovfFlag, irqReq and tickPulse are all 0.
- R2: With periodSel at 0, the counter advances on every clock edge after reset, starting from zero, so tickPulse is high after edges 7994, 15988, 23982, and so on (edges counted from reset release).
- R3: The counter counts 0 up to 0x1F39 inclusive and then returns to 0. One full period is therefore exactly 7994 advances, whatever the advance rate.
- R4: With periodSel at 1, the counter advances only on even-numbered edges counted from reset release, so the overflow period is 15988 cycles. Switching the mode keeps the count value.
- R5: tickPulse is high for exactly one cycle per overflow, in the cycle after the clock edge at which the counter wraps.
- R6: ovfFlag becomes 1 in the same cycle as tickPulse and stays 1 until it is cleared by a read.
- R7: irqReq is 1 exactly when ovfFlag is 1 and irqEn is 1, with no added register delay.
- R8: A statusRd strobe sampled at a clock edge with no overflow at that edge clears ovfFlag from the next cycle on.
- R9: A statusRd strobe sampled at the same edge as an overflow leaves ovfFlag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rstN | input | 1 | Active-low reset, synchronous |
| periodSel | input | 1 | 0: full-rate count, 1: half-rate count (double period) |
| irqEn | input | 1 | Interrupt enable for the overflow flag |
| statusRd | input | 1 | One-cycle strobe: the status register is being read |
| ovfFlag | output | 1 | Sticky overflow flag |
| irqReq | output | 1 | Interrupt request (flag and enable) |
| tickPulse | output | 1 | One-cycle pulse on each overflow |

## Verification
Timing is counted in clock edges from reset release.
- **Tick and flag.** Both are registered at the wrap edge, so both must be seen in the cycle after edge 7994·m in full-rate mode. In half-rate mode the period from the last wrap is 15988 cycles.
- **Interrupt request.** irqReq is combinational, so it follows a change of irqEn within the same cycle.
- **Read strobe.** A strobe takes effect one edge after it is driven.

The bench drives inputs and samples outputs on falling edges, with an edge counter as its time base. A scoreboard queue holds the expected tick edge numbers. The monitor compares each observed pulse against the head of that queue and also checks that the pulse is one cycle wide.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic advance;   // counter steps at this edge
  } tbCmd_t;

  // Events returned from datapath to control
  typedef struct packed {
    logic wrapNow;   // counter at terminal value and advancing
  } tbEvt_t;

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   periodSel,
  input  logic   irqEn,
  input  logic   statusRd,
  input  tbEvt_t evt,
  output tbCmd_t cmd,
  output logic   ovfFlag,
  output logic   irqReq
);

  logic phase;
  logic flagQ;

  // Phase toggles every cycle from reset; half-rate mode advances on phase=1
  always_ff @(posedge clk) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  always_comb begin
    cmd.advance = periodSel ? phase : 1'b1;
  end

  // Set has priority over the read-clear so a colliding event is kept
  always_ff @(posedge clk) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (evt.wrapNow) flagQ <= 1'b1;
    else if (statusRd)    flagQ <= 1'b0;
  end

  assign ovfFlag = flagQ;
  assign irqReq  = flagQ & irqEn;

  // R4: in half-rate mode two consecutive advances never occur
  a_r4_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel && cmd.advance) |=> !(periodSel && cmd.advance));

  // R6: a wrap always leaves the flag set
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrapNow |=> ovfFlag);

  // R8: a read with no overflow clears the flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !evt.wrapNow) |=> !ovfFlag);

  // R9: collision of read and overflow keeps the flag
  a_r9_no_loss: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && evt.wrapNow) |=> ovfFlag);

  // R6: the flag only rises because of a wrap
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(evt.wrapNow));

endmodule

// File: rtl/tbase_dpath.sv
module tbase_dpath
  import tbase_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter logic [CNT_W-1:0] WRAP_VAL = 13'h1F39
)(
  input  logic   clk,
  input  logic   rstN,
  input  tbCmd_t cmd,
  output tbEvt_t evt,
  output logic   tickPulse
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             tickQ;

  always_comb begin
    evt.wrapNow = cmd.advance && (cnt == WRAP_VAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      tickQ <= 1'b0;
    end else begin
      tickQ <= evt.wrapNow;
      if (cmd.advance) begin
        if (evt.wrapNow) cnt <= '0;
        else             cnt <= cnt + ONE;
      end
    end
  end

  assign tickPulse = tickQ;

  // R3: the count never passes the terminal value
  a_r3_bounded: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= WRAP_VAL);

  // R3: no advance means the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.advance |=> $stable(cnt));

  // R5: the tick is never longer than one cycle
  a_r5_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> !tickPulse);

endmodule

// File: rtl/ovf_timebase.sv
module ovf_timebase
  import tbase_pkg::*;
#(
  parameter int CNT_W = 13,
  parameter logic [CNT_W-1:0] WRAP_VAL = 13'h1F39
)(
  input  logic clk,
  input  logic rstN,
  input  logic periodSel,
  input  logic irqEn,
  input  logic statusRd,
  output logic ovfFlag,
  output logic irqReq,
  output logic tickPulse
);

  tbCmd_t cmd;
  tbEvt_t evt;

  tbase_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .periodSel (periodSel),
    .irqEn     (irqEn),
    .statusRd  (statusRd),
    .evt       (evt),
    .cmd       (cmd),
    .ovfFlag   (ovfFlag),
    .irqReq    (irqReq)
  );

  tbase_dpath #(
    .CNT_W    (CNT_W),
    .WRAP_VAL (WRAP_VAL)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .evt       (evt),
    .tickPulse (tickPulse)
  );

  // R6: flag is up whenever the tick is seen
  a_r6_tick_flag: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |-> ovfFlag);

  // R1: outputs quiet in the first cycle after reset release
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!ovfFlag && !tickPulse));

endmodule

// File: tb/tb_ovf_timebase.sv
module tb_ovf_timebase;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodSel = 1'b0;
  logic irqEn = 1'b0;
  logic statusRd = 1'b0;
  logic ovfFlag, irqReq, tickPulse;

  int errs = 0;
  int checks = 0;
  int edgeCnt = 0;
  bit done = 1'b0;
  int expQ[$];
  logic prevTick = 1'b0;

  always #4 clk = ~clk;

  ovf_timebase dut (
    .clk(clk), .rstN(rstN), .periodSel(periodSel), .irqEn(irqEn),
    .statusRd(statusRd), .ovfFlag(ovfFlag), .irqReq(irqReq),
    .tickPulse(tickPulse)
  );

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, edgeCnt, act, exp);
    end
  endtask

  task automatic waitEdge(input int n);
    while (edgeCnt < n) @(negedge clk);
  endtask

  // Monitor: pops expected tick edges and checks pulse width
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (tickPulse) begin
        if (expQ.size() == 0) chk(0, "R2", edgeCnt, -1);
        else begin
          int e;
          e = expQ.pop_front();
          chk(edgeCnt == e, "R2/R4 tick edge", edgeCnt, e);
        end
        chk(!prevTick, "R5 tick width", int'(prevTick), 0);
      end
      prevTick = tickPulse;
    end
  end

  initial begin
    // Driver: expected tick schedule
    expQ.push_back(7994);
    expQ.push_back(15988);
    expQ.push_back(23982);
    expQ.push_back(39970);   // half rate from edge 23982: +2*7994
    expQ.push_back(55958);
    expQ.push_back(63952);   // back to full rate: +7994

    repeat (4) @(negedge clk);
    chk(ovfFlag == 0 && irqReq == 0 && tickPulse == 0, "R1 in reset",
        int'({ovfFlag, irqReq, tickPulse}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ovfFlag == 0 && tickPulse == 0, "R1 after release",
        int'({ovfFlag, tickPulse}), 0);

    waitEdge(7993);
    chk(ovfFlag == 0, "R3 no wrap before 0x1F39", ovfFlag, 0);
    waitEdge(7994);
    chk(ovfFlag == 1, "R6 flag set", ovfFlag, 1);
    chk(irqReq == 0, "R7 irq masked", irqReq, 0);
    waitEdge(8100);
    chk(ovfFlag == 1, "R6 sticky", ovfFlag, 1);
    irqEn = 1'b1;
    #1;
    chk(irqReq == 1, "R7 irq enabled", irqReq, 1);
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    chk(ovfFlag == 0, "R8 read clears", ovfFlag, 1'b0);
    chk(irqReq == 0, "R7 irq drops with flag", irqReq, 0);

    // R9: read sampled at the same edge as the wrap
    waitEdge(15987);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    chk(ovfFlag == 1, "R9 collision keeps flag", ovfFlag, 1);
    chk(irqReq == 1, "R7 irq on collision", irqReq, 1);
    @(negedge clk);
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    chk(ovfFlag == 0, "R8 second clear", ovfFlag, 0);

    waitEdge(23982);
    chk(ovfFlag == 1, "R2 third overflow", ovfFlag, 1);
    periodSel = 1'b1;
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    chk(ovfFlag == 0, "R8 clear before half rate", ovfFlag, 0);

    waitEdge(31976);
    chk(ovfFlag == 0, "R4 no overflow at full period", ovfFlag, 0);
    waitEdge(39969);
    chk(ovfFlag == 0, "R4 no early overflow", ovfFlag, 0);
    waitEdge(39970);
    chk(ovfFlag == 1, "R4 half-rate overflow", ovfFlag, 1);

    waitEdge(55958);
    chk(ovfFlag == 1, "R4 second half-rate overflow", ovfFlag, 1);
    periodSel = 1'b0;

    waitEdge(63960);
    chk(expQ.size() == 0, "R2 all ticks seen", expQ.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      chk(0, "watchdog", edgeCnt, 63960);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule